// File: doc/BRIEF.md
# Programmable Interval Timer for OTG Protocol Windows

The block measures protocol time windows such as bus-idle or disconnect intervals. Software programs a limit in tick units and picks one of four tick periods, all derived from a 1 MHz reference pulse. It then chooses between single-shot and repeating operation and sets the run bit. Each tick advances a readable count. When the count reaches the limit, a sticky interrupt status bit is set, and that bit drives the interrupt pin.

A single-shot run drops its own run bit and leaves the count at the limit. A repeating run wraps the count to zero and raises the interrupt again on every match. Software stops a run by clearing the run bit, which also zeroes the count. It acknowledges an interrupt by writing a one to the acknowledge register.

Top module: `otg_interval_timer`

## Requirements
- R1: After reset the control register, limit, count and interrupt status all read 0 and `irq_o` is low.
- R2: While running, the count rises by one per tick. With tick select 2'b00 a tick is every 10 reference pulses. When the count reaches the limit, the status bit is set on that same tick.
- R3: Tick select 2'b00, 2'b01, 2'b10 and 2'b11 give a tick every 10, 100, 1000 and 10000 reference pulses (10 us, 100 us, 1 ms, 10 ms).
- R4: With the mode bit (control bit 1) at 0, the run bit (control bit 0) clears itself on expiry and the count holds at the limit. Writing the run bit from 0 to 1 restarts the count from 0.
- R5: The status bit stays set until a write to address 2 with data bit 0 equal to 1. A write there with bit 0 equal to 0 has no effect.
- R6: With the mode bit at 1, the count wraps to 0 on each match, the status bit is set again on every match, and the run bit stays 1.
- R7: A control write with the run bit at 0 stops the timer and forces the count to 0.
- R8: A limit of 0 expires on the first tick after the run starts.
- R9: When an acknowledge write and an expiry fall in the same cycle, the status bit ends up set.
- R10: Neither the prescaler nor the count advances in cycles without a reference pulse.
- R11: The register map is as follows. Address 0 is control: bit 0 run, bit 1 mode, bits 3:2 tick select. Address 1 is the limit. Address 2 reads the status in bit 0. Address 3 reads the count, and writes to it are ignored. `irq_o` equals the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | One-cycle pulse at 1 MHz |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Interrupt, level of the sticky status bit |

## Verification
The hardest case to reach is an acknowledge write that lands on the very cycle a repeating run matches again. The scoreboard covers it by counting edges from the enabling write. It places one acknowledge in the middle of a period, then issues the next acknowledge so that it takes effect on the edge of the second match. Both actions are timed against the known period of 20 reference pulses. The test for missing reference pulses holds the pulse low through a long wait and then releases it. This shows that the prescaler starts from zero.

// File: rtl/otg_tmr_pkg.sv
// Shared constants for the OTG interval timer: register addresses,
// control field positions, tick-select encodings and the divider function.
package otg_tmr_pkg;

    typedef enum logic [1:0] {
        TICK_10US  = 2'b00,
        TICK_100US = 2'b01,
        TICK_1MS   = 2'b10,
        TICK_10MS  = 2'b11
    } tick_sel_e;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_LIMIT = 2'd1;
    localparam logic [1:0] ADDR_ACK   = 2'd2;
    localparam logic [1:0] ADDR_COUNT = 2'd3;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_BIT = 1;
    localparam int CTRL_SEL_LSB  = 2;

    // Reference pulses per tick for a given select; base is the finest divisor.
    function automatic int unsigned tick_div(input logic [1:0] sel, input int unsigned base);
        case (sel)
            TICK_10US:  return base;
            TICK_100US: return base * 10;
            TICK_1MS:   return base * 100;
            default:    return base * 1000;
        endcase
    endfunction

endpackage

// File: rtl/otg_tmr_prescaler.sv
// Tick prescaler: counts reference pulses and emits a one-cycle tick every
// N pulses, where N follows the tick select. Assumes ref_en is a one-cycle
// pulse. The prescaler is held at zero while the timer is not running, so
// every run starts on a full tick period.
module otg_tmr_prescaler
    import otg_tmr_pkg::*;
#(
    parameter int unsigned BASE_DIV = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ref_en,
    input  logic [1:0] sel,
    output logic       tick
);

    localparam int unsigned MAX_DIV = BASE_DIV * 1000;
    localparam int          PRE_W   = $clog2(MAX_DIV);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] last_val;

    // Terminal prescaler value for the selected tick period.
    always_comb last_val = PRE_W'(tick_div(sel, BASE_DIV) - 1);

    assign tick = run && ref_en && (pre_cnt >= last_val);

    // Reference pulse counter, cleared while stopped and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run) begin
            pre_cnt <= '0;
        end else if (ref_en) begin
            pre_cnt <= (pre_cnt >= last_val) ? '0 : pre_cnt + 1'b1;
        end
    end

    // R10: without a reference pulse a running prescaler does not move.
    a_r10_hold_without_ref: assert property (@(posedge clk) disable iff (!rst_n)
        run && !ref_en |=> $stable(pre_cnt))
        else $error("prescaler moved without reference pulse");

endmodule

// File: rtl/otg_tmr_counter.sv
// Interval counter: advances on each tick and compares the next value with
// the limit. On a match it either holds at the limit (single-shot) or wraps
// to zero (repeating). A restart request zeroes it. Assumes tick is only
// asserted while running.
module otg_tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             free_run,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic [CNT_W:0] next_wide;

    // Widened increment so the compare cannot overflow at the top value.
    always_comb next_wide = {1'b0, count} + 1'b1;

    assign expire = tick && (next_wide >= {1'b0, limit});

    // Count register: restart, then match handling, then plain increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (expire) begin
            count <= free_run ? '0 : limit;
        end else if (tick) begin
            count <= next_wide[CNT_W-1:0];
        end
    end

    // R7: a restart request leaves the count at zero.
    a_r7_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count == '0)
        else $error("count not zeroed by restart");

    // R2: the count changes only on ticks or restarts.
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !restart |=> $stable(count))
        else $error("count moved without a tick");

    // R6: a repeating match wraps the count.
    a_r6_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        expire && free_run && !restart |=> count == '0)
        else $error("repeating run did not wrap");

endmodule

// File: rtl/otg_tmr_regs.sv
// Register block: holds the control fields, the limit and the sticky status.
// It decodes writes, forms the restart request and muxes reads. Expiry
// takes priority over an acknowledge in the same cycle. A control write
// takes priority over the self-clear of the run bit.
module otg_tmr_regs
    import otg_tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic              run,
    output logic              free_run,
    output logic [1:0]        sel,
    output logic [CNT_W-1:0]  limit,
    output logic              restart,
    output logic              status
);

    logic ctrl_wr;
    logic limit_wr;
    logic ack_wr;

    // Write address decode.
    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
        limit_wr = wr_en && (wr_addr == ADDR_LIMIT);
        ack_wr   = wr_en && (wr_addr == ADDR_ACK) && wr_data[0];
    end

    // Restart on stop, or on a start from the stopped state.
    assign restart = ctrl_wr && !(run && wr_data[CTRL_RUN_BIT]);

    // Run bit: software write, else self-clear on a single-shot expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else if (ctrl_wr) begin
            run <= wr_data[CTRL_RUN_BIT];
        end else if (expire && !free_run) begin
            run <= 1'b0;
        end
    end

    // Mode, tick select and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_run <= 1'b0;
            sel      <= 2'b00;
            limit    <= '0;
        end else begin
            if (ctrl_wr) begin
                free_run <= wr_data[CTRL_MODE_BIT];
                sel      <= wr_data[CTRL_SEL_LSB +: 2];
            end
            if (limit_wr) begin
                limit <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Sticky status: expiry sets it and wins over an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (expire) begin
            status <= 1'b1;
        end else if (ack_wr) begin
            status <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CTRL: begin
                rd_data[CTRL_RUN_BIT]        = run;
                rd_data[CTRL_MODE_BIT]       = free_run;
                rd_data[CTRL_SEL_LSB +: 2]   = sel;
            end
            ADDR_LIMIT: rd_data[CNT_W-1:0] = limit;
            ADDR_ACK:   rd_data[0]         = status;
            default:    rd_data[CNT_W-1:0] = count;
        endcase
    end

    // R5: the status holds unless acknowledged.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        status && !ack_wr |=> status)
        else $error("status dropped without acknowledge");

    // R5: an acknowledge with no expiry clears the status.
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr && !expire |=> !status)
        else $error("acknowledge did not clear status");

    // R9: an expiry always leaves the status set.
    a_r9_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status)
        else $error("expiry lost");

    // R4: a single-shot expiry drops the run bit.
    a_r4_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !free_run && !ctrl_wr |=> !run)
        else $error("run bit not self-cleared");

endmodule

// File: rtl/otg_interval_timer.sv
// Top of the OTG interval timer: connects the register block, the tick
// prescaler and the interval counter. Assumes ref_tick_i is a one-cycle
// pulse at 1 MHz in the clk domain. The read data is combinational.
module otg_interval_timer #(
    parameter int          CNT_W    = 16,
    parameter int          DATA_W   = 32,
    parameter int unsigned BASE_DIV = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);

    logic             run;
    logic             free_run;
    logic [1:0]       sel;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             restart;
    logic             expire;
    logic             tick;
    logic             status;

    otg_tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o),
        .count    (count),
        .expire   (expire),
        .run      (run),
        .free_run (free_run),
        .sel      (sel),
        .limit    (limit),
        .restart  (restart),
        .status   (status)
    );

    otg_tmr_prescaler #(.BASE_DIV(BASE_DIV)) i_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .ref_en (ref_tick_i),
        .sel    (sel),
        .tick   (tick)
    );

    otg_tmr_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .restart  (restart),
        .free_run (free_run),
        .limit    (limit),
        .count    (count),
        .expire   (expire)
    );

    assign irq_o = status;

endmodule

// File: tb/test_otg_interval_timer.sv
`timescale 1ns/100ps
module test_otg_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_on = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];
    event        sb_ev;

    always #4 clk = ~clk;

    otg_interval_timer i_otg_interval_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_on),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .irq_o      (irq)
    );

    // Monitor: pops expected items and compares them with the outputs.
    always @(sb_ev) begin
        while (q_kind.size() > 0) begin
            int          k;
            logic [31:0] e;
            logic [31:0] a;
            string       t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            a = (k == 0) ? rd_data : {31'b0, irq};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s actual=%0h expected=%0h", t, a, e);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    // Driver side: push an expected read value.
    task automatic exp_rd(input logic [1:0] a, input logic [31:0] e, input string t);
        rd_addr = a;
        #0.1;
        q_kind.push_back(0);
        q_exp.push_back(e);
        q_tag.push_back(t);
        -> sb_ev;
        #0.1;
    endtask

    task automatic exp_irq(input logic e, input string t);
        q_kind.push_back(1);
        q_exp.push_back({31'b0, e});
        q_tag.push_back(t);
        -> sb_ev;
        #0.1;
    endtask

    // Acknowledge, load the limit, then start with a control word.
    task automatic start(input logic [15:0] lim, input logic [3:0] ctrl);
        wr(2'd1, {16'b0, lim});
        wr(2'd2, 32'd1);
        wr(2'd0, {28'b0, ctrl});
    endtask

    task automatic stop_all();
        wr(2'd0, 32'd0);
        wr(2'd2, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        exp_rd(2'd0, 32'd0, "R1 ctrl");
        exp_rd(2'd1, 32'd0, "R1 limit");
        exp_rd(2'd2, 32'd0, "R1 status");
        exp_rd(2'd3, 32'd0, "R1 count");
        exp_irq(1'b0, "R1 irq");

        // R11 readback and ignored count write
        wr(2'd0, 32'hE);
        exp_rd(2'd0, 32'hE, "R11 ctrl readback");
        wr(2'd1, 32'h1234);
        exp_rd(2'd1, 32'h1234, "R11 limit readback");
        wr(2'd3, 32'h55);
        exp_rd(2'd3, 32'd0, "R11 count write ignored");
        stop_all();

        // R2 single-shot, 10 us tick, limit 5: expiry 50 edges after start
        start(16'd5, 4'b0001);
        step(24);
        exp_rd(2'd3, 32'd2, "R2 count mid-run");
        step(25);
        exp_rd(2'd2, 32'd0, "R2 no early expiry");
        exp_rd(2'd3, 32'd4, "R2 count before match");
        step(1);
        exp_rd(2'd2, 32'd1, "R2 expiry on time");
        exp_irq(1'b1, "R11 irq follows status");
        exp_rd(2'd3, 32'd5, "R4 count at limit");
        exp_rd(2'd0, 32'd0, "R4 run self-cleared");
        step(50);
        exp_rd(2'd3, 32'd5, "R4 count holds");
        exp_rd(2'd2, 32'd1, "R5 status sticky");
        wr(2'd2, 32'd0);
        exp_rd(2'd2, 32'd1, "R5 ack with bit0 zero ignored");
        wr(2'd2, 32'd1);
        exp_rd(2'd2, 32'd0, "R5 ack clears");
        exp_irq(1'b0, "R5 irq low after ack");
        wr(2'd0, 32'd1);
        exp_rd(2'd3, 32'd0, "R4 restart from zero");
        stop_all();

        // R3 tick selects
        start(16'd3, 4'b0101);
        step(299);
        exp_rd(2'd2, 32'd0, "R3 100us early");
        step(1);
        exp_rd(2'd2, 32'd1, "R3 100us expiry");
        stop_all();
        start(16'd2, 4'b1001);
        step(1999);
        exp_rd(2'd2, 32'd0, "R3 1ms early");
        step(1);
        exp_rd(2'd2, 32'd1, "R3 1ms expiry");
        stop_all();
        start(16'd1, 4'b1101);
        step(9999);
        exp_rd(2'd2, 32'd0, "R3 10ms early");
        step(1);
        exp_rd(2'd2, 32'd1, "R3 10ms expiry");
        stop_all();

        // R6 repeating, limit 4, 10 us tick
        start(16'd4, 4'b0011);
        step(39);
        exp_rd(2'd2, 32'd0, "R6 before first match");
        exp_rd(2'd3, 32'd3, "R6 count before match");
        step(1);
        exp_rd(2'd2, 32'd1, "R6 first match");
        exp_rd(2'd3, 32'd0, "R6 wrap");
        exp_rd(2'd0, 32'd3, "R6 run stays set");
        wr(2'd2, 32'd1);
        exp_rd(2'd2, 32'd0, "R6 ack");
        step(38);
        exp_rd(2'd2, 32'd0, "R6 before second match");
        step(1);
        exp_rd(2'd2, 32'd1, "R6 second match");
        stop_all();

        // R7 stop zeroes count
        start(16'd100, 4'b0011);
        step(55);
        exp_rd(2'd3, 32'd5, "R7 running count");
        wr(2'd0, 32'd2);
        exp_rd(2'd3, 32'd0, "R7 stop zeroes count");
        step(30);
        exp_rd(2'd3, 32'd0, "R7 stays stopped");
        exp_rd(2'd2, 32'd0, "R7 no expiry when stopped");
        stop_all();

        // R8 limit 0 expires on first tick
        start(16'd0, 4'b0001);
        step(9);
        exp_rd(2'd2, 32'd0, "R8 before first tick");
        step(1);
        exp_rd(2'd2, 32'd1, "R8 expiry on first tick");
        exp_rd(2'd3, 32'd0, "R8 count");
        stop_all();

        // R9 ack and expiry in the same cycle, repeating limit 2
        start(16'd2, 4'b0011);
        step(24);
        wr(2'd2, 32'd1);
        exp_rd(2'd2, 32'd0, "R9 mid-period ack");
        step(14);
        wr(2'd2, 32'd1);
        exp_rd(2'd2, 32'd1, "R9 expiry wins over ack");
        exp_rd(2'd3, 32'd0, "R9 wrapped");
        stop_all();

        // R10 no progress without reference pulses
        ref_on = 1'b0;
        start(16'd1, 4'b0001);
        step(100);
        exp_rd(2'd3, 32'd0, "R10 count idle");
        exp_rd(2'd2, 32'd0, "R10 no expiry");
        ref_on = 1'b1;
        step(9);
        exp_rd(2'd2, 32'd0, "R10 prescaler fresh");
        step(1);
        exp_rd(2'd2, 32'd1, "R10 expiry after pulses resume");
        stop_all();

        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule